// File: doc/BRIEF.md
# Periodic Countdown Timer with Maskable Interrupt

This block is a countdown timer on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Software writes a reload limit, then uses a control word to load that limit into the counter, start the counter or stop it. The same control word chooses which of several prescaled tick rates drives the counter, or chooses a code that holds the counter still.

While the timer runs, each enabled tick lowers the count by one. When the count runs out, the timer reloads the limit and flags a pending event, so it produces a steady period of `limit` ticks. A mask register decides whether a pending event drives the level interrupt output. A write-one-to-clear acknowledge register removes pending bits, and a masked-status register shows which pending bits are currently enabled.

Top module: `cd_timer`

## Requirements
- R1: After reset the counter, limit, control word, mask and pending registers read zero, the timer is stopped and `irq_o` is low.
- R2: A write to offset 0x00 sets the reload limit, which reads back at 0x00; it neither changes the counter nor starts it.
- R3: The control word at offset 0x08 carries an operation in bits [1:0]: 0 copies the limit into the counter, 1 stops counting with the count held, 2 starts or resumes counting. The last accepted word reads back in bits [4:0].
- R4: A control write with operation 3 is ignored as a whole: the control readback, the count and the run state stay as they were.
- R5: Bits [4:2] of the control word select the tick source. Codes 4, 5, 6 and 7 tick once every 1, 2, 4 and 8 clock cycles; codes 0 to 3 give no ticks, so a running counter does not move.
- R6: A tick that finds the count at 1 or 0 is an expiry: the counter reloads the limit and bit 0 of the pending register is set. With a limit of L the first expiry comes L ticks after the start, and later expiries follow every L ticks.
- R7: The mask register at offset 0x48 stores the whole written word and reads it back unchanged.
- R8: `irq_o` is high exactly when some bit is set in both the pending and the mask register; with mask bit 0 clear an expiry leaves `irq_o` low, and setting the mask afterward raises it.
- R9: A write to offset 0x4C clears each pending bit whose written bit is 1 and leaves the rest; `irq_o` falls only once pending AND mask is zero.
- R10: An expiry in the same cycle as an acknowledge that clears bit 0 leaves bit 0 set.
- R11: Offset 0x04 reads the current count and ignores writes; 0x50 reads the raw pending bits; 0x54 reads pending AND mask; 0x4C and every unmapped offset read zero.
- R12: A valid control write takes priority over a tick in the same cycle: that cycle's tick neither decrements the counter nor expires it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register being accessed |
| we_i | input | 1 | Write strobe, one write per cycle it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational from register state |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims a stop at the cycle right after a start. A design that let the tick win over the control write would read one count lower, and a design that failed to hold the count while stopped would drift afterward. It places an acknowledge on the exact cycle of an expiry, where a design that gave the clear priority would lose the event. It runs the counter with the mask clear, where a design that ignored the mask would raise the interrupt early. It also measures the expiry period on three tick sources, where a wrong prescaler tap or an off-by-one reload shows up as a wrong cycle count.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFF_LIMIT = 8'h00;
    localparam logic [7:0] OFF_COUNT = 8'h04;
    localparam logic [7:0] OFF_CTRL  = 8'h08;
    localparam logic [7:0] OFF_MASK  = 8'h48;
    localparam logic [7:0] OFF_ACK   = 8'h4C;
    localparam logic [7:0] OFF_RAW   = 8'h50;
    localparam logic [7:0] OFF_MSKD  = 8'h54;

    // Width of the tick-source select field and the first code that ticks
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned SEL_FIRST = 4;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_STOP = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    // Packed so that op sits in bits [1:0] and sel in bits [4:2]
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        op_e              op;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cdt_ticksel.sv
`timescale 1ns/1ps
module cdt_ticksel #(
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned SRC_STEP = 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [cdt_pkg::SEL_W-1:0] sel_i,
    output logic                      tick_o
);
    import cdt_pkg::*;

    localparam int unsigned SPAN  = (NUM_SRC - 1) * SRC_STEP;
    localparam int unsigned PRE_W = (SPAN > 0) ? SPAN : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Source g ticks once every 2**(g*SRC_STEP) cycles
    logic [NUM_SRC-1:0] src_tick;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g == 0) begin : g_every
            assign src_tick[g] = 1'b1;
        end else begin : g_div
            assign src_tick[g] = &st_q.pre[g*SRC_STEP-1:0];
        end
    end

    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(SEL_FIRST + i)) tick_o = src_tick[i];
        end
    end

endmodule

// File: rtl/cdt_count.sv
`timescale 1ns/1ps
module cdt_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lim_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             ctrl_we_i,
    input  cdt_pkg::op_e     op_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] limit_o,
    output logic             run_o,
    output logic             expire_o
);
    import cdt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
        logic             run;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (lim_we_i) st_d.limit = wdata_i;
        if (ctrl_we_i) begin
            // control write wins over any tick this cycle
            case (op_i)
                OP_LOAD: st_d.count = st_q.limit;
                OP_STOP: st_d.run   = 1'b0;
                OP_RUN:  st_d.run   = 1'b1;
                default: ;
            endcase
        end else if (st_q.run && tick_i) begin
            if (st_q.count <= CNT_W'(1)) begin
                expire_o   = 1'b1;
                st_d.count = st_q.limit;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign limit_o = st_q.limit;
    assign run_o   = st_q.run;

endmodule

// File: rtl/cdt_irq.sv
`timescale 1ns/1ps
module cdt_irq #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SRC_BIT = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              expire_i,
    input  logic              mask_we_i,
    input  logic              ack_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] pend_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
        logic              irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we_i) st_d.mask = wdata_i;
        if (ack_we_i)  st_d.pend = st_q.pend & ~wdata_i;
        // a fresh expiry overrides a clear in the same cycle
        if (expire_i)  st_d.pend[SRC_BIT] = 1'b1;
        st_d.irq = |(st_d.pend & st_d.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/cd_timer.sv
`timescale 1ns/1ps
module cd_timer #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned SRC_STEP = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    import cdt_pkg::*;

    // ---------------- address decode ----------------
    logic sel_limit, sel_count, sel_ctrl, sel_mask, sel_ack, sel_raw, sel_mskd;

    assign sel_limit = (addr_i == ADDR_W'(OFF_LIMIT));
    assign sel_count = (addr_i == ADDR_W'(OFF_COUNT));
    assign sel_ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
    assign sel_mask  = (addr_i == ADDR_W'(OFF_MASK));
    assign sel_ack   = (addr_i == ADDR_W'(OFF_ACK));
    assign sel_raw   = (addr_i == ADDR_W'(OFF_RAW));
    assign sel_mskd  = (addr_i == ADDR_W'(OFF_MSKD));

    ctrl_t wr_ctrl;
    logic  ctrl_wr_ok;

    assign wr_ctrl    = ctrl_t'(wdata_i[CTRL_W-1:0]);
    assign ctrl_wr_ok = we_i && sel_ctrl && (wr_ctrl.op != OP_BAD);

    // ---------------- control register ----------------
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr_ok) ctrl_d = wr_ctrl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    logic [SEL_W-1:0] cur_sel;
    assign cur_sel = ctrl_q.sel;

    // ---------------- tick source ----------------
    logic tick;

    cdt_ticksel #(
        .NUM_SRC (NUM_SRC),
        .SRC_STEP(SRC_STEP)
    ) u_ticksel (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sel_i (cur_sel),
        .tick_o(tick)
    );

    // ---------------- counter ----------------
    logic [DATA_W-1:0] cnt_count, cnt_limit;
    logic              cnt_run, cnt_expire;

    cdt_count #(
        .CNT_W(DATA_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lim_we_i (we_i && sel_limit),
        .wdata_i  (wdata_i),
        .ctrl_we_i(ctrl_wr_ok),
        .op_i     (wr_ctrl.op),
        .tick_i   (tick),
        .count_o  (cnt_count),
        .limit_o  (cnt_limit),
        .run_o    (cnt_run),
        .expire_o (cnt_expire)
    );

    // ---------------- interrupt state ----------------
    logic [DATA_W-1:0] irq_pend, irq_mask;

    cdt_irq #(
        .DATA_W (DATA_W),
        .SRC_BIT(0)
    ) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .expire_i (cnt_expire),
        .mask_we_i(we_i && sel_mask),
        .ack_we_i (we_i && sel_ack),
        .wdata_i  (wdata_i),
        .pend_o   (irq_pend),
        .mask_o   (irq_mask),
        .irq_o    (irq_o)
    );

    // ---------------- read mux ----------------
    always_comb begin
        rdata_o = '0;
        unique case (1'b1)
            sel_limit: rdata_o = cnt_limit;
            sel_count: rdata_o = cnt_count;
            sel_ctrl:  rdata_o = DATA_W'(ctrl_q);
            sel_mask:  rdata_o = irq_mask;
            sel_raw:   rdata_o = irq_pend;
            sel_mskd:  rdata_o = irq_pend & irq_mask;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/cdt_checker.sv
`timescale 1ns/1ps
module cdt_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      we_i,
    input logic [ADDR_W-1:0]         addr_i,
    input logic [1:0]                wlow_i,
    input logic                      irq_o,
    input logic [DATA_W-1:0]         count_i,
    input logic [DATA_W-1:0]         limit_i,
    input logic                      run_i,
    input logic [cdt_pkg::CTRL_W-1:0] ctrl_i,
    input logic                      expire_i,
    input logic [DATA_W-1:0]         pend_i,
    input logic [DATA_W-1:0]         mask_i
);
    import cdt_pkg::*;

    logic ctrl_hit, ctrl_wr, ack_wr;
    assign ctrl_hit = we_i && (addr_i == ADDR_W'(OFF_CTRL));
    assign ctrl_wr  = ctrl_hit && (wlow_i != 2'd3);
    assign ack_wr   = we_i && (addr_i == ADDR_W'(OFF_ACK));

    // R3: stopped counter only moves through a control write
    a_r3_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !ctrl_hit) |=> $stable(count_i));

    // R4: illegal operation leaves control and run state alone
    a_r4_bad_op_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_hit && wlow_i == 2'd3) |=> ($stable(ctrl_i) && $stable(run_i)));

    // R5: non-ticking select codes freeze a running counter
    a_r5_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && ctrl_i[CTRL_W-1:2] < SEL_W'(SEL_FIRST) && !ctrl_hit) |=> $stable(count_i));

    // R6: expiry reloads the limit
    a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> (count_i == $past(limit_i)));

    // R8: interrupt level follows pending AND mask
    a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == |(pend_i & mask_i));

    // R9: acknowledging bit 0 clears it when no expiry coincides
    a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_wr && wlow_i[0] && !expire_i) |=> !pend_i[0]);

    // R10: an expiry always leaves bit 0 pending
    a_r10_expiry_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> pend_i[0]);

    // R12: no expiry in a cycle that carries a valid control write
    a_r12_ctrl_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr |-> !expire_i);

endmodule

bind cd_timer cdt_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wlow_i  (wdata_i[1:0]),
    .irq_o   (irq_o),
    .count_i (cnt_count),
    .limit_i (cnt_limit),
    .run_i   (cnt_run),
    .ctrl_i  (ctrl_q),
    .expire_i(cnt_expire),
    .pend_i  (irq_pend),
    .mask_i  (irq_mask)
);

// File: tb/test_cd_timer.sv
`timescale 1ns/1ps
module test_cd_timer;

    localparam logic [7:0] A_LIMIT = 8'h00;
    localparam logic [7:0] A_COUNT = 8'h04;
    localparam logic [7:0] A_CTRL  = 8'h08;
    localparam logic [7:0] A_MASK  = 8'h48;
    localparam logic [7:0] A_ACK   = 8'h4C;
    localparam logic [7:0] A_RAW   = 8'h50;
    localparam logic [7:0] A_MSKD  = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int unsigned cyc = 0;
    int unsigned last_wr_edge = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cd_timer i_cd_timer (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .addr_i (addr),
        .we_i   (we),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .irq_o  (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];

    task automatic note(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        item_t it;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            note(it.tag, it.is_irq ? {31'b0, irq} : rdata, it.exp);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #2;
        we = 1'b0;
        last_wr_edge = cyc;
    endtask

    task automatic wr_at(input int unsigned n, input logic [7:0] a, input logic [31:0] d);
        while (1) begin
            @(posedge clk); #2;
            if (cyc >= n - 1) break;
        end
        note("setup of aligned write", cyc, n - 1);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #2;
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        addr = a; we = 1'b0;
        sbq.push_back('{1'b0, exp, tag});
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(posedge clk); #2;
        sbq.push_back('{1'b1, {31'b0, exp}, tag});
    endtask

    task automatic wait_irq(output int unsigned e);
        do @(negedge clk); while (!irq);
        e = cyc;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin
        int unsigned e1, e2, w;

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // reset state
        rd(A_LIMIT, 32'h0, "R1 limit after reset");
        rd(A_COUNT, 32'h0, "R1 count after reset");
        rd(A_CTRL,  32'h0, "R1 ctrl after reset");
        rd(A_MASK,  32'h0, "R1 mask after reset");
        rd(A_RAW,   32'h0, "R1 pending after reset");
        rd(A_MSKD,  32'h0, "R1 masked after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // limit write alone
        wr(A_LIMIT, 32'd5);
        rd(A_LIMIT, 32'd5, "R2 limit readback");
        rd(A_COUNT, 32'd0, "R2 count untouched by limit write");

        // load, then start and stop on consecutive writes
        wr(A_CTRL, 32'h10);
        rd(A_COUNT, 32'd5, "R3 load copies limit");
        rd(A_CTRL,  32'h10, "R3 ctrl readback");
        wr(A_CTRL, 32'h12);
        wr(A_CTRL, 32'h11);
        rd(A_COUNT, 32'd4, "R12 stop write beats tick");
        repeat (10) @(posedge clk);
        rd(A_COUNT, 32'd4, "R3 stop holds count");

        // illegal op
        wr(A_CTRL, 32'h1F);
        rd(A_CTRL, 32'h11, "R4 illegal op leaves ctrl");
        repeat (6) @(posedge clk);
        rd(A_COUNT, 32'd4, "R4 illegal op leaves count");

        // read-only count and zero reads
        wr(A_COUNT, 32'h77);
        rd(A_COUNT, 32'd4, "R11 count ignores writes");
        rd(8'h20, 32'h0, "R11 unmapped reads zero");
        rd(A_ACK, 32'h0, "R11 ack reads zero");

        // non-ticking select codes
        wr(A_CTRL, 32'h02);
        repeat (20) @(posedge clk);
        rd(A_COUNT, 32'd4, "R5 select 0 holds count");
        wr(A_CTRL, 32'h06);
        repeat (20) @(posedge clk);
        rd(A_COUNT, 32'd4, "R5 select 1 holds count");
        wr(A_CTRL, 32'h01);

        // expiry with mask clear, then mask
        wr(A_LIMIT, 32'd4);
        wr(A_CTRL, 32'h10);
        wr(A_CTRL, 32'h12);
        repeat (12) @(posedge clk);
        chk_irq(1'b0, "R8 masked-off expiry keeps irq low");
        wr(A_CTRL, 32'h11);
        rd(A_RAW,  32'h1, "R6 expiry sets pending bit 0");
        rd(A_MSKD, 32'h0, "R11 masked read with mask clear");
        chk_irq(1'b0, "R8 irq low with mask clear");
        wr(A_MASK, 32'hA5A5_0001);
        rd(A_MASK, 32'hA5A5_0001, "R7 mask readback");
        rd(A_MSKD, 32'h1, "R11 masked read with mask set");
        chk_irq(1'b1, "R8 irq rises on mask");
        wr(A_ACK, 32'h0);
        rd(A_RAW, 32'h1, "R9 ack of zeros clears nothing");
        chk_irq(1'b1, "R9 irq stays with pending left");
        wr(A_ACK, 32'hFFFF_FFFF);
        rd(A_RAW, 32'h0, "R9 ack clears pending");
        chk_irq(1'b0, "R9 irq falls after ack");

        // period on the every-cycle source
        wr(A_LIMIT, 32'd6);
        wr(A_CTRL, 32'h10);
        wr(A_CTRL, 32'h12);
        w = last_wr_edge;
        wait_irq(e1);
        note("R6 first expiry after start", e1 - w, 32'd6);
        wr(A_ACK, 32'h1);
        wait_irq(e2);
        note("R6 reload period", e2 - e1, 32'd6);
        wr_at(e2 + 6, A_ACK, 32'h1);
        rd(A_RAW, 32'h1, "R10 expiry beats same-cycle ack");
        chk_irq(1'b1, "R10 irq held");
        wr(A_CTRL, 32'h11);
        wr(A_ACK, 32'h1);
        chk_irq(1'b0, "R9 irq low after final ack");

        // period on the divide-by-2 source
        wr(A_LIMIT, 32'd4);
        wr(A_CTRL, 32'h14);
        wr(A_CTRL, 32'h16);
        wait_irq(e1);
        wr(A_ACK, 32'h1);
        wait_irq(e2);
        note("R5 select 5 period", e2 - e1, 32'd8);
        wr(A_CTRL, 32'h15);
        wr(A_ACK, 32'h1);

        // period on the divide-by-8 source
        wr(A_LIMIT, 32'd3);
        wr(A_CTRL, 32'h1C);
        wr(A_CTRL, 32'h1E);
        wait_irq(e1);
        wr(A_ACK, 32'h1);
        wait_irq(e2);
        note("R5 select 7 period", e2 - e1, 32'd24);
        wr(A_CTRL, 32'h1D);
        wr(A_ACK, 32'h1);
        rd(A_RAW, 32'h0, "R9 pending clear at end");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule